// File: doc/BRIEF.md
# Crystal Oscillator Bias Trim Controller

This block steers the bias current of a crystal oscillator through a small trim code. An analog comparator pair reports whether the bias is too high (HI flag) or whether it is large enough for reliable oscillation (LO flag). Each new trim code needs time to settle, so the controller waits a programmable number of time-base ticks after every write before it looks at the flags.

Software or a power sequencer picks one of three operations. Search mode runs a successive-approximation search from zero to find the lowest code that sets LO, then adds a safety margin. Switch mode starts from the current code and walks it up or down until the flags agree. It then issues a one-cycle strobe that tells the clock tree the crystal may be selected. Check mode applies a single corrective step and is meant to run periodically. Mode encoding on `mode_i`: 0 = search, 1 = switch, 2 = check, 3 = no operation.

Top module: `bias_trim_ctrl`

## Requirements
- R1: During and after reset, `trim_o` is 0 and `busy_o`, `done_o` and `xtal_sel_o` are 0.
- R2: Search (mode 0) first writes only the most significant bit, then tests each bit from MSB to LSB. A bit is kept only while LO reads clear. After the last bit, one more settle is done at the result. If LO is still clear then, the code is incremented. Finally 2 is added, saturating at the maximum code 15.
- R3: After each trim write the flags are sampled only once `SETTLE_TICKS` pulses of `tick_i` have been counted. With `tick_i` low, the controller holds. A search makes TRIM_W+1 settle waits.
- R4: Switch (mode 1) samples after each settle. It increments when LO is clear and decrements when HI is set and the code is above 2. It repeats while the flags disagree and the code is strictly between 2 and 15.
- R5: When the switch walk ends, 2 is added (saturating at 15) if LO was clear or the code is below 2. If that offset or any decrement occurred, one extra write-and-settle precedes completion.
- R6: `xtal_sel_o` pulses for one cycle only at the end of a switch operation, in the same cycle as `done_o`.
- R7: Check (mode 2) completes with `busy_o` high for exactly one cycle. It decrements on HI set, then increments and adds the saturating offset of 2 on LO clear.
- R8: Check mode clamps its result to at least 2.
- R9: A start while busy, or a start with mode 3, has no effect on the code, the state or the timing.
- R10: `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls.
- R11: `trim_o` does not change while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Settle time-base enable (one pulse per microsecond in normal use) |
| start_i | input | 1 | Start request, taken only when idle |
| mode_i | input | 2 | 0 search, 1 switch, 2 check, 3 none |
| hi_i | input | 1 | Comparator flag: bias too high |
| lo_i | input | 1 | Comparator flag: bias sufficient |
| trim_o | output | TRIM_W | Bias trim code to the oscillator |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| xtal_sel_o | output | 1 | One-cycle strobe permitting crystal selection |

## Verification
On every cycle the assertions check the following: the done and select pulses are single-cycle and paired with idle; the code floor holds at completion; the code stays quiet while idle; the settle counter stays in range; the search mask stays one-hot; and the state does not move during a wait. The actual codes each mode converges to can only be shown by the bench scenarios. The same holds for the number of settle waits, the ceiling and floor exits of the switch walk, and the rejected start requests. The bench drives the flags from a threshold model of the oscillator.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        BT_SEARCH = 2'd0,
        BT_SWITCH = 2'd1,
        BT_CHECK  = 2'd2,
        BT_NONE   = 2'd3
    } bt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRCH_WAIT,
        ST_SRCH_LAST,
        ST_SW_WAIT,
        ST_SW_LAST,
        ST_CHECK
    } bt_state_e;

endpackage

// File: rtl/bt_settle_timer.sv
module bt_settle_timer #(
    parameter int SETTLE_TICKS = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && tick_i && (cnt_q == LAST);
        cnt_d    = cnt_q;
        if (!run_i || expire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the settle count never passes its terminal value
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: an idle timer holds at zero
    assert_count_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/bt_trim_step.sv
module bt_trim_step #(
    parameter int TRIM_W   = 4,
    parameter int TRIM_MIN = 2,
    parameter int OFFSET   = 2
) (
    input  logic [TRIM_W-1:0] trim_i,
    input  logic              hi_i,
    input  logic              lo_i,
    output logic [TRIM_W-1:0] last_trim_o,
    output logic [TRIM_W-1:0] chk_trim_o,
    output logic [TRIM_W-1:0] sw_trim_o,
    output logic              sw_dec_o,
    output logic              sw_cont_o,
    output logic [TRIM_W-1:0] sw_final_o,
    output logic              sw_off_o
);
    localparam int EW   = TRIM_W + 2;
    localparam int MAXV = (1 << TRIM_W) - 1;
    localparam logic [EW-1:0] MAX_E = EW'(MAXV);
    localparam logic [EW-1:0] MIN_E = EW'(TRIM_MIN);
    localparam logic [EW-1:0] OFF_E = EW'(OFFSET);
    localparam logic [EW-1:0] SAT_E = EW'(MAXV - OFFSET);

    function automatic logic [EW-1:0] sat_off(input logic [EW-1:0] v);
        return (v < SAT_E) ? v + OFF_E : MAX_E;
    endfunction

    logic [EW-1:0] base, srch_v, chk_a, chk_b, chk_c, sw_a, sw_b, sw_f;

    always_comb begin
        base = {2'b00, trim_i};

        // search epilogue: bump if still low, then margin
        srch_v      = sat_off(base + (lo_i ? EW'(0) : EW'(1)));
        last_trim_o = srch_v[TRIM_W-1:0];

        // periodic check step
        chk_a      = (hi_i && base != '0) ? base - EW'(1) : base;
        chk_b      = lo_i ? chk_a : sat_off(chk_a + EW'(1));
        chk_c      = (chk_b < MIN_E) ? MIN_E : chk_b;
        chk_trim_o = chk_c[TRIM_W-1:0];

        // switch walk step
        sw_a      = lo_i ? base : base + EW'(1);
        sw_dec_o  = hi_i && (sw_a > MIN_E);
        sw_b      = sw_dec_o ? sw_a - EW'(1) : sw_a;
        sw_trim_o = sw_b[TRIM_W-1:0];
        sw_cont_o = (hi_i || !lo_i) && (sw_b < MAX_E) && (sw_b > MIN_E);
        sw_off_o  = !lo_i || (sw_b < OFF_E);
        sw_f      = sw_off_o ? sat_off(sw_b) : sw_b;
        sw_final_o = sw_f[TRIM_W-1:0];
    end

endmodule

// File: rtl/bias_trim_ctrl.sv
module bias_trim_ctrl
    import bt_pkg::*;
#(
    parameter int TRIM_W       = 4,
    parameter int TRIM_MIN     = 2,
    parameter int OFFSET       = 2,
    parameter int SETTLE_TICKS = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              hi_i,
    input  logic              lo_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              xtal_sel_o
);
    localparam logic [TRIM_W-1:0] MSB_MASK = {1'b1, {(TRIM_W-1){1'b0}}};

    typedef struct packed {
        bt_state_e         st;
        logic [TRIM_W-1:0] trim;
        logic [TRIM_W-1:0] bitm;
        logic              adj;
        logic              done;
        logic              sel;
    } regs_t;

    regs_t q, d;

    logic              run, expire;
    logic [TRIM_W-1:0] last_trim, chk_trim, sw_trim, sw_final, srch_keep;
    logic              sw_dec, sw_cont, sw_off;

    assign run = (q.st == ST_SRCH_WAIT) || (q.st == ST_SRCH_LAST) ||
                 (q.st == ST_SW_WAIT)   || (q.st == ST_SW_LAST);

    bt_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .tick_i  (tick_i),
        .expire_o(expire)
    );

    bt_trim_step #(.TRIM_W(TRIM_W), .TRIM_MIN(TRIM_MIN), .OFFSET(OFFSET)) u_step (
        .trim_i     (q.trim),
        .hi_i       (hi_i),
        .lo_i       (lo_i),
        .last_trim_o(last_trim),
        .chk_trim_o (chk_trim),
        .sw_trim_o  (sw_trim),
        .sw_dec_o   (sw_dec),
        .sw_cont_o  (sw_cont),
        .sw_final_o (sw_final),
        .sw_off_o   (sw_off)
    );

    assign srch_keep = lo_i ? (q.trim & ~q.bitm) : q.trim;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sel  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    unique case (bt_mode_e'(mode_i))
                        BT_SEARCH: begin
                            d.trim = MSB_MASK;
                            d.bitm = MSB_MASK;
                            d.st   = ST_SRCH_WAIT;
                        end
                        BT_SWITCH: begin
                            d.adj = 1'b0;
                            d.st  = ST_SW_WAIT;
                        end
                        BT_CHECK:  d.st = ST_CHECK;
                        default:   d.st = ST_IDLE;
                    endcase
                end
            end
            ST_SRCH_WAIT: begin
                if (expire) begin
                    if (q.bitm[0]) begin
                        d.trim = srch_keep;
                        d.st   = ST_SRCH_LAST;
                    end else begin
                        d.bitm = q.bitm >> 1;
                        d.trim = srch_keep | (q.bitm >> 1);
                    end
                end
            end
            ST_SRCH_LAST: begin
                if (expire) begin
                    d.trim = last_trim;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            ST_SW_WAIT: begin
                if (expire) begin
                    if (sw_cont) begin
                        d.trim = sw_trim;
                        d.adj  = q.adj | sw_dec;
                    end else begin
                        d.trim = sw_final;
                        if (q.adj || sw_dec || sw_off) begin
                            d.st = ST_SW_LAST;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.sel  = 1'b1;
                        end
                    end
                end
            end
            ST_SW_LAST: begin
                if (expire) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.sel  = 1'b1;
                end
            end
            ST_CHECK: begin
                d.trim = chk_trim;
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.trim <= '0;
            q.bitm <= '0;
            q.adj  <= 1'b0;
            q.done <= 1'b0;
            q.sel  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign trim_o     = q.trim;
    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign xtal_sel_o = q.sel;

    // R10: completion is a single-cycle pulse seen while idle
    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !busy_o);

    // R6: the crystal strobe only accompanies completion
    assert_sel_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.sel |-> q.done);

    // R8 (also R2, R5): every finished operation leaves at least the floor code
    assert_trim_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.trim >= TRIM_W'(TRIM_MIN));

    // R11: no code movement while idle without a request
    assert_trim_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !start_i) |=> $stable(q.trim));

    // R2: the search probe mask always holds exactly one bit
    assert_search_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SRCH_WAIT) |-> $onehot(q.bitm));

    // R9 (also R3): a waiting controller moves only on timer expiry
    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> ($stable(q.st) && $stable(q.trim)));

endmodule

// File: tb/bias_trim_ctrl_bench.sv
`timescale 1ns/1ps
module bias_trim_ctrl_bench;
    localparam int N = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       hi, lo;
    logic [3:0] trim;
    logic       busy, done, sel;
    logic [4:0] lo_thr = 5'd0;
    logic [4:0] hi_thr = 5'd15;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    // oscillator model: LO once code reaches lo_thr, HI once code exceeds hi_thr
    assign lo = ({1'b0, trim} >= lo_thr);
    assign hi = ({1'b0, trim} > hi_thr);

    bias_trim_ctrl #(.TRIM_W(4), .TRIM_MIN(2), .OFFSET(2), .SETTLE_TICKS(N)) u_bias_trim_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .mode_i(mode),
        .hi_i(hi), .lo_i(lo), .trim_o(trim), .busy_o(busy), .done_o(done), .xtal_sel_o(sel)
    );

    typedef struct packed {
        logic [1:0] m;
        logic [4:0] l;
        logic [4:0] h;
        logic [3:0] exp_trim;
        logic [7:0] exp_busy;
        logic       exp_sel;
    } vec_t;

    // mode: 0 search, 1 switch, 2 check; busy counts in cycles with N = 3
    localparam vec_t VEC [20] = '{
        '{2'd0, 5'd5,  5'd15, 4'd7,  8'd15, 1'b0},
        '{2'd1, 5'd5,  5'd10, 4'd7,  8'd3,  1'b1},
        '{2'd1, 5'd10, 5'd14, 4'd10, 8'd12, 1'b1},
        '{2'd0, 5'd5,  5'd15, 4'd7,  8'd15, 1'b0},
        '{2'd1, 5'd0,  5'd4,  4'd4,  8'd15, 1'b1},
        '{2'd0, 5'd5,  5'd15, 4'd7,  8'd15, 1'b0},
        '{2'd1, 5'd0,  5'd1,  4'd2,  8'd18, 1'b1},
        '{2'd2, 5'd0,  5'd1,  4'd2,  8'd1,  1'b0},
        '{2'd2, 5'd0,  5'd15, 4'd2,  8'd1,  1'b0},
        '{2'd0, 5'd12, 5'd15, 4'd14, 8'd15, 1'b0},
        '{2'd1, 5'd16, 5'd15, 4'd15, 8'd6,  1'b1},
        '{2'd2, 5'd16, 5'd15, 4'd15, 8'd1,  1'b0},
        '{2'd0, 5'd0,  5'd15, 4'd2,  8'd15, 1'b0},
        '{2'd0, 5'd16, 5'd15, 4'd15, 8'd15, 1'b0},
        '{2'd0, 5'd13, 5'd15, 4'd15, 8'd15, 1'b0},
        '{2'd0, 5'd1,  5'd15, 4'd3,  8'd15, 1'b0},
        '{2'd0, 5'd8,  5'd15, 4'd10, 8'd15, 1'b0},
        '{2'd2, 5'd0,  5'd4,  4'd9,  8'd1,  1'b0},
        '{2'd2, 5'd12, 5'd15, 4'd12, 8'd1,  1'b0},
        '{2'd2, 5'd14, 5'd10, 4'd14, 8'd1,  1'b0}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            summary();
        end
    end

    task automatic run_op(input logic [1:0] m, input logic [4:0] l, input logic [4:0] h,
                          input int inject_at, output int bcnt, output logic d, output logic s);
        lo_thr = l;
        hi_thr = h;
        mode   = m;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bcnt  = 0;
        while (busy && bcnt < 1000) begin
            bcnt++;
            if (bcnt == inject_at) begin
                start = 1'b1;
                mode  = 2'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        d = done;
        s = sel;
    endtask

    initial begin
        int   bc;
        logic dn, sl;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(trim == 4'd0 && !busy && !done && !sel, "R1 in reset", trim, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trim == 4'd0 && !busy && !done && !sel, "R1 after reset", trim, 0);

        for (int i = 0; i < 20; i++) begin
            string tag;
            tag = (VEC[i].m == 2'd0) ? "R2 search" : (VEC[i].m == 2'd1) ? "R4 R5 switch" : "R7 R8 check";
            run_op(VEC[i].m, VEC[i].l, VEC[i].h, 0, bc, dn, sl);
            chk(trim == VEC[i].exp_trim, tag, trim, VEC[i].exp_trim);
            chk(bc == int'(VEC[i].exp_busy), (VEC[i].m == 2'd2) ? "R7 busy cycles" : "R3 settle waits",
                bc, VEC[i].exp_busy);
            chk(dn == 1'b1, "R10 done at end", dn, 1);
            chk(sl == VEC[i].exp_sel, "R6 select strobe", sl, VEC[i].exp_sel);
            @(negedge clk);
            chk(!done && !sel, "R10 done single cycle", done, 0);
            chk(trim == VEC[i].exp_trim, "R11 idle code stable", trim, VEC[i].exp_trim);
        end

        // R9: mode 3 request does nothing
        mode  = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !done, "R9 mode 3 ignored", busy, 0);
        @(negedge clk);
        chk(trim == 4'd14 && !done, "R9 mode 3 code kept", trim, 14);

        // R9: start while busy ignored (check request injected mid-search)
        run_op(2'd0, 5'd5, 5'd15, 4, bc, dn, sl);
        chk(trim == 4'd7, "R9 busy start ignored code", trim, 7);
        chk(bc == 15, "R9 busy start ignored timing", bc, 15);
        @(negedge clk);

        // R3: no ticks, no progress
        lo_thr = 5'd5;
        hi_thr = 5'd15;
        tick   = 1'b0;
        mode   = 2'd0;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy && trim == 4'd8, "R3 hold without ticks", trim, 8);
        tick = 1'b1;
        bc = 0;
        while (busy && bc < 1000) begin
            bc++;
            @(negedge clk);
        end
        chk(bc == 15, "R3 wait resumes", bc, 15);
        chk(trim == 4'd7 && done, "R2 result after hold", trim, 7);

        summary();
    end
endmodule